// File: doc/BRIEF.md
# Digital Potentiometer Serial Command Decoder

This block is the serial slave front end of a single-channel digital potentiometer controller. A host selects it by pulling the chip-select line low and then clocks bits in on the data input, sampled on each rising serial clock edge. The block runs on its own system clock. It passes the serial pins through synchronizers and detects clock and select edges by oversampling. Every frame begins with a header byte that holds a device type nibble and an address bit. The block compares these with a fixed type and with a strap pin. A second byte then carries a three-bit opcode and a two-bit register pointer.

Transfer commands take effect as soon as the two header bytes are in. Write commands take two more bytes that carry a 10-bit value, right-aligned. Read commands send a 10-bit value from the attached register bank back on the serial output during those two bytes. The block issues one strobe for each completed write or transfer, along with the opcode, the register pointer and the value. A pause input freezes the serial transfer. The block ignores all serial traffic until chip select has fallen at least once after reset.

Top module: `dpot_spi_decoder`

## Requirements
- R1: While reset is asserted, and right after it is released, `cmd_valid` and `spi_sdo_oe` are both 0.
- R2: After reset no frame is decoded until `spi_cs_n` has gone from high to low. Clocking in a complete, valid command with chip select held low since reset gives no strobe.
- R3: Bits are taken MSB first on rising `spi_sck` while `spi_cs_n` is low. In the first byte, bits 7..4 must equal 0101. Otherwise the rest of the frame is ignored and no strobe is issued. Bit 0 is the direction flag and bits 3..2 are not checked.
- R4: Bit 1 of the first byte must equal `dev_addr`. On a mismatch the rest of the frame is ignored.
- R5: In the second byte, bits 7..5 are the opcode and bits 3..2 are the register pointer (0 to 3, binary). The opcodes are: 100 read wiper, 101 write wiper, 110 data register to wiper, 111 wiper to data register, 001 read data register, 010 write data register, 011 read status. Code 000 aborts the frame with no strobe and no serial output.
- R6: The opcodes 110 and 111 are complete after the second byte. They give one `cmd_valid` pulse with `cmd_op` and `cmd_reg` taken from that byte.
- R7: The opcodes 101 and 010 give one `cmd_valid` pulse after the fourth byte. `cmd_data` is {byte3[1:0], byte4[7:0]}.
- R8: For the opcodes 100, 001 and 011, the block shifts out the 16 bits {6'b0, `rd_value`} on `spi_sdo` during bytes 3 and 4, MSB first. Each bit changes after a falling `spi_sck`. `rd_value` must reflect `cmd_op`/`cmd_reg` from the end of byte 2 onward. Reads give no strobe.
- R9: `spi_sdo_oe` is 0 whenever chip select is high and during every frame that is not a read. The output is treated as high-impedance whenever `spi_sdo_oe` is 0.
- R10: While `spi_pause_n` is low, clock edges neither shift data in nor shift data out. Once it returns high the frame continues unchanged.
- R11: If chip select rises before a command is complete, the partial command is discarded and no strobe follows.
- R12: Each frame gives at most one strobe. Bytes that follow a completed command are ignored until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_sdi | input | 1 | Serial data in |
| spi_pause_n | input | 1 | Pause input: low freezes the transfer |
| dev_addr | input | 1 | Address strap compared with bit 1 of the first byte |
| rd_value | input | VAL_W | Value of the register selected by `cmd_op`/`cmd_reg`, driven by the bank |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_oe | output | 1 | Output enable for `spi_sdo` (0 means high-impedance) |
| cmd_valid | output | 1 | One-cycle strobe for a completed write or transfer |
| cmd_op | output | 3 | Opcode of the current or last command |
| cmd_reg | output | 2 | Register pointer of the current or last command |
| cmd_data | output | VAL_W | Value carried by a write command |

## Verification
On every cycle the assertions check four things. A strobe only follows a cycle spent inside a frame. Only write or transfer opcodes ever strobe, and no strobe repeats or appears after chip select has risen. The output enable never rises outside a frame, and a paused bus never completes a byte. The bench scenarios are needed to show the rest. These include the header comparisons against the device type and the strap, the exact bit positions of opcode, pointer and value, and the order of the serialized read data. The scenarios also cover the arming rule after reset, and that a frame split by a pause gives the same result as an unbroken one.

// File: rtl/dpot_cmd_pkg.sv
package dpot_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b0101;

  typedef enum logic [2:0] {
    OP_NONE        = 3'b000,
    OP_RD_DR       = 3'b001,
    OP_WR_DR       = 3'b010,
    OP_RD_ST       = 3'b011,
    OP_RD_WIPER    = 3'b100,
    OP_WR_WIPER    = 3'b101,
    OP_DR_TO_WIPER = 3'b110,
    OP_WIPER_TO_DR = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_INSTR,
    ST_DHI,
    ST_DLO,
    ST_DONE
  } state_e;

  function automatic logic op_is_read(op_e op);
    return (op == OP_RD_WIPER) || (op == OP_RD_DR) || (op == OP_RD_ST);
  endfunction

endpackage

// File: rtl/dpot_pin_sync.sv
module dpot_pin_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    logic [WIDTH-1:0] stg_r;
    if (s == 0) begin : g_in
      assign stg_d = d;
    end else begin : g_chain
      assign stg_d = g_stage[s-1].stg_r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_r <= RST_VAL;
      else        stg_r <= stg_d;
    end
  end

  assign q = g_stage[STAGES-1].stg_r;

endmodule

// File: rtl/dpot_bit_shift.sv
module dpot_bit_shift
  import dpot_cmd_pkg::*;
#(
  parameter int TX_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rx_en,
  input  logic              si,
  input  logic              tx_load,
  input  logic [TX_W-1:0]   tx_word,
  input  logic              tx_en,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              sdo
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic [TX_W-1:0]   tx_q, tx_d;
  logic              sdo_q, sdo_d;

  always_comb begin
    rx_d   = rx_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    tx_d   = tx_q;
    sdo_d  = sdo_q;
    if (clr) begin
      cnt_d = '0;
    end else if (rx_en) begin
      rx_d   = {rx_q[BYTE_W-2:0], si};
      cnt_d  = cnt_q + CNT_W'(1);
      done_d = (cnt_q == CNT_LAST);
    end
    if (tx_load) begin
      tx_d = tx_word;
    end else if (tx_en) begin
      sdo_d = tx_q[TX_W-1];
      tx_d  = {tx_q[TX_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      tx_q   <= '0;
      sdo_q  <= 1'b0;
    end else begin
      rx_q   <= rx_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      tx_q   <= tx_d;
      sdo_q  <= sdo_d;
    end
  end

  assign rx_byte   = rx_q;
  assign byte_done = done_q;
  assign sdo       = sdo_q;

endmodule

// File: rtl/dpot_cmd_ctrl.sv
module dpot_cmd_ctrl
  import dpot_cmd_pkg::*;
#(
  parameter int VAL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              dev_addr,
  output logic              in_frame,
  output logic              rd_phase,
  output logic              tx_load,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [1:0]        cmd_reg,
  output logic [VAL_W-1:0]  cmd_data
);

  localparam int HI_W = VAL_W - BYTE_W;

  state_e           state_q, state_d;
  op_e              op_q, op_d;
  logic [1:0]       reg_q, reg_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic [VAL_W-1:0] data_q, data_d;
  logic             valid_q, valid_d;
  logic             load_q, load_d;
  op_e              rx_op;

  assign rx_op = op_e'(rx_byte[7:5]);

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    reg_d   = reg_q;
    hi_d    = hi_q;
    data_d  = data_q;
    valid_d = 1'b0;
    load_d  = 1'b0;
    if (frame_end) begin
      state_d = ST_IDLE;
    end else if (frame_start) begin
      state_d = ST_ID;
    end else if (byte_done) begin
      case (state_q)
        ST_ID: begin
          if ((rx_byte[7:4] == DEV_TYPE) && (rx_byte[1] == dev_addr)) state_d = ST_INSTR;
          else                                                         state_d = ST_DONE;
        end
        ST_INSTR: begin
          op_d  = rx_op;
          reg_d = rx_byte[3:2];
          case (rx_op)
            OP_DR_TO_WIPER, OP_WIPER_TO_DR: begin
              valid_d = 1'b1;
              state_d = ST_DONE;
            end
            OP_RD_WIPER, OP_RD_DR, OP_RD_ST: begin
              load_d  = 1'b1;
              state_d = ST_DHI;
            end
            OP_WR_WIPER, OP_WR_DR: state_d = ST_DHI;
            default:               state_d = ST_DONE;
          endcase
        end
        ST_DHI: begin
          hi_d    = rx_byte[HI_W-1:0];
          state_d = ST_DLO;
        end
        ST_DLO: begin
          if (!op_is_read(op_q)) begin
            valid_d = 1'b1;
            data_d  = {hi_q, rx_byte};
          end
          state_d = ST_DONE;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      reg_q   <= '0;
      hi_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      reg_q   <= reg_d;
      hi_q    <= hi_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      load_q  <= load_d;
    end
  end

  assign in_frame  = (state_q != ST_IDLE);
  assign rd_phase  = ((state_q == ST_DHI) || (state_q == ST_DLO)) && op_is_read(op_q);
  assign tx_load   = load_q;
  assign cmd_valid = valid_q;
  assign cmd_op    = op_q;
  assign cmd_reg   = reg_q;
  assign cmd_data  = data_q;

  AST_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($past(state_q) != ST_IDLE)); // R2
  AST_STROBE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (op_q == OP_WR_WIPER || op_q == OP_WR_DR ||
                 op_q == OP_DR_TO_WIPER || op_q == OP_WIPER_TO_DR)); // R6
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R12
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !valid_q); // R11

endmodule

// File: rtl/dpot_spi_decoder.sv
module dpot_spi_decoder
  import dpot_cmd_pkg::*;
#(
  parameter int VAL_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sck,
  input  logic             spi_sdi,
  input  logic             spi_pause_n,
  input  logic             dev_addr,
  input  logic [VAL_W-1:0] rd_value,
  output logic             spi_sdo,
  output logic             spi_sdo_oe,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [1:0]       cmd_reg,
  output logic [VAL_W-1:0] cmd_data
);

  localparam int TX_W  = 2 * BYTE_W;
  localparam int PAD_W = TX_W - VAL_W;
  localparam int PIN_W = 4;

  logic [PIN_W-1:0] pins_s;
  logic cs_s, sck_s, sdi_s, hold_s;
  logic cs_d_q, sck_d_q, oe_q, oe_d;
  logic sck_rise, sck_fall, cs_fall, cs_rise;
  logic rx_en, tx_en;
  logic in_frame, rd_phase, tx_load, byte_done, sdo_bit;
  logic [BYTE_W-1:0] rx_byte;

  // pause resets to "not paused"; select resets low so a held-low select never arms
  dpot_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_pause_n, spi_sdi, spi_sck, spi_cs_n}),
    .q     (pins_s)
  );
  assign {hold_s, sdi_s, sck_s, cs_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d_q  <= 1'b0;
      sck_d_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      cs_d_q  <= cs_s;
      sck_d_q <= sck_s;
      oe_q    <= oe_d;
    end
  end

  assign sck_rise = sck_s & ~sck_d_q;
  assign sck_fall = ~sck_s & sck_d_q;
  assign cs_fall  = ~cs_s & cs_d_q;
  assign cs_rise  = cs_s & ~cs_d_q;
  assign rx_en    = sck_rise & hold_s & in_frame & ~cs_s;
  assign tx_en    = sck_fall & hold_s & rd_phase & ~cs_s;
  assign oe_d     = rd_phase & hold_s & ~cs_s;

  dpot_bit_shift #(.TX_W(TX_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cs_fall),
    .rx_en     (rx_en),
    .si        (sdi_s),
    .tx_load   (tx_load),
    .tx_word   ({{PAD_W{1'b0}}, rd_value}),
    .tx_en     (tx_en),
    .rx_byte   (rx_byte),
    .byte_done (byte_done),
    .sdo       (sdo_bit)
  );

  dpot_cmd_ctrl #(.VAL_W(VAL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (cs_fall),
    .frame_end   (cs_rise),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .dev_addr    (dev_addr),
    .in_frame    (in_frame),
    .rd_phase    (rd_phase),
    .tx_load     (tx_load),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_reg     (cmd_reg),
    .cmd_data    (cmd_data)
  );

  assign spi_sdo    = sdo_bit;
  assign spi_sdo_oe = oe_q;

  AST_SDO_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sdo_oe |-> in_frame); // R9
  AST_HOLD_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |=> !byte_done); // R10

endmodule

// File: tb/tb_dpot_spi_decoder.sv
module tb_dpot_spi_decoder;

  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam int VAL_W = 10;

  logic clk, rst_n, spi_cs_n, spi_sck, spi_sdi, spi_pause_n, dev_addr;
  logic [VAL_W-1:0] rd_value, cmd_data;
  logic spi_sdo, spi_sdo_oe, cmd_valid;
  logic [2:0] cmd_op;
  logic [1:0] cmd_reg;

  int errors = 0;
  int checks = 0;
  int strobe_cnt = 0;
  int oe_cnt = 0;
  int desel_run = 0;
  int desel_bad = 0;
  logic [2:0] s_op;
  logic [1:0] s_reg;
  logic [VAL_W-1:0] s_data;

  dpot_spi_decoder #(.VAL_W(VAL_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_sdi(spi_sdi), .spi_pause_n(spi_pause_n), .dev_addr(dev_addr),
    .rd_value(rd_value), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_data(cmd_data)
  );

  // register bank model: value depends on the selected opcode and pointer
  assign rd_value = 10'h2C9 ^ {5'd0, cmd_op, cmd_reg};

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      strobe_cnt++;
      s_op   = cmd_op;
      s_reg  = cmd_reg;
      s_data = cmd_data;
    end
    if (spi_sdo_oe) oe_cnt++;
    if (spi_cs_n) desel_run++;
    else          desel_run = 0;
    if (desel_run > 6 && spi_sdo_oe) desel_bad++;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] id_b(input logic a, input logic rw);
    return {4'b0101, 2'b00, a, rw};
  endfunction

  function automatic logic [7:0] ins_b(input logic [2:0] op, input logic [1:0] rg);
    return {op, 1'b0, rg, 2'b00};
  endfunction

  task automatic xfer_byte(input logic [7:0] b, input bit pause_mid, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      spi_sdi = b[i];
      wait_clk(HALF);
      r[i] = spi_sdo;
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
      if (pause_mid && i == 4) begin
        wait_clk(HALF);
        spi_pause_n = 1'b0;
        wait_clk(HALF);
        for (int p = 0; p < 2; p++) begin
          spi_sdi = ~spi_sdi;
          spi_sck = 1'b1; wait_clk(HALF);
          spi_sck = 1'b0; wait_clk(HALF);
        end
        spi_pause_n = 1'b1;
        wait_clk(HALF);
      end
    end
  endtask

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [15:0] dat,
                       input int nbytes, input int pause_byte, output logic [15:0] rd);
    logic [7:0] r;
    logic [7:0] tx_b;
    rd = '0;
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < nbytes; k++) begin
      case (k)
        0:       tx_b = b0;
        1:       tx_b = b1;
        2:       tx_b = dat[15:8];
        default: tx_b = dat[7:0];
      endcase
      xfer_byte(tx_b, (pause_byte == k), r);
      if (k == 2) rd[15:8] = r;
      if (k == 3) rd[7:0]  = r;
    end
    wait_clk(2*HALF);
    spi_cs_n = 1'b1;
    wait_clk(3*HALF);
  endtask

  initial begin
    logic [15:0] rd;
    logic [2:0] wops [2];
    logic [2:0] xops [2];
    logic [2:0] rops [3];
    logic [VAL_W-1:0] val;
    int n0, o0;
    wops = '{3'b101, 3'b010};
    xops = '{3'b110, 3'b111};
    rops = '{3'b100, 3'b001, 3'b011};

    rst_n = 1'b0; spi_cs_n = 1'b0; spi_sck = 1'b0; spi_sdi = 1'b0;
    spi_pause_n = 1'b1; dev_addr = 1'b0;
    wait_clk(5);
    chk("R1", "cmd_valid in reset", cmd_valid, 0);
    chk("R1", "sdo_oe in reset", spi_sdo_oe, 0);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R1", "cmd_valid after reset", cmd_valid, 0);
    chk("R1", "sdo_oe after reset", spi_sdo_oe, 0);

    // R2: select low since reset, no falling edge yet
    n0 = strobe_cnt;
    frame(id_b(1'b0, 1'b0), ins_b(3'b101, 2'd1), 16'h0155, 4, -1, rd);
    chk("R2", "strobes before arming", strobe_cnt - n0, 0);

    // R7 / R5: write sweep over strap, opcode, pointer, values
    for (int a = 0; a < 2; a++) begin
      dev_addr = a[0];
      for (int oi = 0; oi < 2; oi++) begin
        for (int rg = 0; rg < 4; rg++) begin
          for (int vi = 0; vi < 3; vi++) begin
            if (vi == 0)      val = '0;
            else if (vi == 1) val = 10'h3FF;
            else              val = VAL_W'((a*317 + rg*89 + oi*53 + 7) % 1024);
            n0 = strobe_cnt; o0 = oe_cnt;
            frame(id_b(a[0], 1'b0), ins_b(wops[oi], rg[1:0]), {6'b0, val}, 4, -1, rd);
            chk("R7", "write strobe count", strobe_cnt - n0, 1);
            chk("R5", "write opcode", s_op, wops[oi]);
            chk("R5", "write pointer", s_reg, rg);
            chk("R7", "write data", s_data, val);
            chk("R9", "sdo_oe during write", oe_cnt - o0, 0);
          end
        end
      end
    end

    // R6 / R12: transfers, with trailing bytes that must be ignored
    for (int a = 0; a < 2; a++) begin
      dev_addr = a[0];
      for (int oi = 0; oi < 2; oi++) begin
        for (int rg = 0; rg < 4; rg++) begin
          n0 = strobe_cnt;
          frame(id_b(a[0], 1'b0), ins_b(xops[oi], rg[1:0]), 16'hFFFF, (rg == 0) ? 2 : 4, -1, rd);
          chk("R12", "transfer strobe count", strobe_cnt - n0, 1);
          chk("R6", "transfer opcode", s_op, xops[oi]);
          chk("R6", "transfer pointer", s_reg, rg);
        end
      end
    end

    // R8: reads return {6'b0, bank value} MSB first; R10 pause inside read data
    dev_addr = 1'b1;
    for (int oi = 0; oi < 3; oi++) begin
      for (int rg = 0; rg < 4; rg++) begin
        n0 = strobe_cnt; o0 = oe_cnt;
        frame(id_b(1'b1, 1'b1), ins_b(rops[oi], rg[1:0]), 16'h0000, 4, (rg == 3) ? 2 : -1, rd);
        chk((rg == 3) ? "R10" : "R8", "read data", rd,
            {6'b0, 10'h2C9 ^ {5'd0, rops[oi], rg[1:0]}});
        chk("R8", "read gives no strobe", strobe_cnt - n0, 0);
        chk("R9", "sdo_oe active in read", (oe_cnt - o0) > 0, 1);
      end
    end

    // R3: every wrong device type nibble
    dev_addr = 1'b0;
    for (int nib = 0; nib < 16; nib++) begin
      if (nib != 5) begin
        n0 = strobe_cnt;
        frame({nib[3:0], 2'b00, 1'b0, 1'b0}, ins_b(3'b101, 2'd2), 16'h0123, 4, -1, rd);
        chk("R3", "bad device type ignored", strobe_cnt - n0, 0);
      end
    end

    // R4: strap mismatch both ways
    for (int a = 0; a < 2; a++) begin
      dev_addr = a[0];
      n0 = strobe_cnt; o0 = oe_cnt;
      frame(id_b(~a[0], 1'b0), ins_b(3'b110, 2'd1), 16'h0000, 2, -1, rd);
      chk("R4", "address mismatch transfer", strobe_cnt - n0, 0);
      frame(id_b(~a[0], 1'b1), ins_b(3'b100, 2'd0), 16'h0000, 4, -1, rd);
      chk("R4", "address mismatch read oe", oe_cnt - o0, 0);
    end

    // R5: opcode 000 aborts
    dev_addr = 1'b0;
    n0 = strobe_cnt; o0 = oe_cnt;
    frame(id_b(1'b0, 1'b0), ins_b(3'b000, 2'd3), 16'h03FF, 4, -1, rd);
    chk("R5", "opcode 000 no strobe", strobe_cnt - n0, 0);
    chk("R5", "opcode 000 no output", oe_cnt - o0, 0);

    // R11: select rises early
    n0 = strobe_cnt;
    frame(id_b(1'b0, 1'b0), ins_b(3'b101, 2'd0), 16'h0377, 3, -1, rd);
    chk("R11", "write cut after 3 bytes", strobe_cnt - n0, 0);
    frame(id_b(1'b0, 1'b0), ins_b(3'b111, 2'd2), 16'h0000, 1, -1, rd);
    chk("R11", "transfer cut after 1 byte", strobe_cnt - n0, 0);
    frame(id_b(1'b0, 1'b0), ins_b(3'b010, 2'd3), 16'h0000, 2, -1, rd);
    chk("R11", "write cut after header", strobe_cnt - n0, 0);
    frame(id_b(1'b0, 1'b0), ins_b(3'b010, 2'd3), 16'h0234, 4, -1, rd);
    chk("R11", "recovery strobe", strobe_cnt - n0, 1);
    chk("R11", "recovery data", s_data, 10'h234);

    // R10: pause inside the first header byte and inside the last data byte
    for (int pb = 0; pb < 4; pb += 3) begin
      n0 = strobe_cnt;
      frame(id_b(1'b0, 1'b0), ins_b(3'b101, 2'd1), 16'h02B6, 4, pb, rd);
      chk("R10", "paused write strobe", strobe_cnt - n0, 1);
      chk("R10", "paused write data", s_data, 10'h2B6);
    end

    chk("R9", "sdo_oe while deselected", desel_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule